// File: doc/BRIEF.md
# Write-Path Byte Parity Checker

This block sits on the write-data input of a synchronous memory. It checks every byte lane that is being written against a parity sense that is strapped at board level, and it signals a failure on an active-low error line that can only pull low. The data bus is split into nine-bit lanes. Each lane holds eight data bits and one parity bit, and all nine bits take part in the check. Lanes whose write enable is off in a cycle are not judged. Cycles that are not writes, such as reads or idle cycles, are never judged.

The latency of the error report follows the access mode of the memory. In flow-through mode an error appears in the clock cycle right after the bad data was presented. In pipelined mode it appears one cycle later than that. Each report lasts exactly one cycle. The error line drives low on an error and is otherwise left floating, so several such lines can share one pull-up and together form a wired-AND. A separate active-high copy of the pull-down enable is also provided.

Top module: `wr_parity_guard`

## Requirements
- R1: When `wr_cycle` is low in a cycle, the data in that cycle never causes an error report, whatever its value.
- R2: With `pipe_sel` low (flow-through), an error in the data sampled at clock edge N is reported in the cycle that starts at edge N+1.
- R3: With `pipe_sel` high (pipelined), an error in the data sampled at edge N is reported in the cycle that starts at edge N+2.
- R4: With `even_sel` high, a lane passes when its nine bits hold an even number of ones. With `even_sel` low, a lane passes when they hold an odd number of ones.
- R5: Lane k occupies `wr_data[9k+8:9k]`, and all nine of its bits count. An error is reported if any enabled lane fails.
- R6: A lane whose bit in `lane_we` is 0 is ignored in that cycle. If only disabled lanes fail, no error is reported.
- R7: Each report lasts exactly one cycle. Failing writes in consecutive cycles give reports in consecutive cycles, with none merged or lost.
- R8: While `rst_n` is low, and until an error reaches the output after reset, `err_drive_low` is 0 and the line is released.
- R9: `err_n` is driven to 0 exactly when `err_drive_low` is 1, and it is high impedance otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_cycle | input | 1 | High in a cycle that writes data |
| lane_we | input | 4 | Per-lane write enable |
| wr_data | input | 36 | Four nine-bit lanes, each eight data bits plus one parity bit |
| even_sel | input | 1 | 1 selects even parity, 0 selects odd parity (static) |
| pipe_sel | input | 1 | 1 selects pipelined latency, 0 selects flow-through latency (static) |
| err_drive_low | output | 1 | High while the error line is being pulled low |
| err_n | output | 1 | Open-drain error line: 0 on error, high impedance otherwise |

## Verification
Two functions can meet in the same cycle: a new failing write being captured, and the report of an earlier failing write leaving the output. In pipelined mode the report of the cycle before that can be in flight as well. The bench provokes this with long runs of writes presented every cycle, with a random mix of read cycles, lane enables and bad lanes. It keeps a shift history of expected flags, computed from lane popcounts, and compares the output in every cycle against the entry one or two cycles back. An exhaustive 512-value sweep of lane 0 in each mode and parity sense covers the nine-bit parity rule.

// File: rtl/wpg_pkg.sv
package wpg_pkg;
    typedef struct packed {
        logic st1;
        logic st2;
    } wpg_state_t;
endpackage

// File: rtl/wpg_lane_check.sv
module wpg_lane_check #(
    parameter int LANE_W = 9
) (
    input  logic [LANE_W-1:0] lane,
    input  logic              even_sel,
    output logic              bad
);
    // odd popcount fails even sense; even popcount fails odd sense
    always_comb begin
        bad = (^lane) ^ ~even_sel;
    end
endmodule

// File: rtl/wpg_reduce.sv
module wpg_reduce #(
    parameter int LANES = 4
) (
    input  logic             wr_cycle,
    input  logic [LANES-1:0] lane_we,
    input  logic [LANES-1:0] lane_bad,
    output logic             cycle_bad
);
    logic [LANES-1:0] masked;
    always_comb begin
        masked    = lane_bad & lane_we;
        cycle_bad = wr_cycle & (|masked);
    end
endmodule

// File: rtl/wpg_delay.sv
module wpg_delay
    import wpg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sample_bad,
    input  logic pipe_sel,
    output logic flag
);
    wpg_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.st1 = sample_bad;
        st_d.st2 = st_q.st1;
        flag     = pipe_sel ? st_q.st2 : st_q.st1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/wr_parity_guard.sv
module wr_parity_guard #(
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_cycle,
    input  logic [LANES-1:0]        lane_we,
    input  logic [LANES*LANE_W-1:0] wr_data,
    input  logic                    even_sel,
    input  logic                    pipe_sel,
    output logic                    err_drive_low,
    output wire                     err_n
);
    localparam int DW = LANES * LANE_W;

    logic [LANES-1:0] lane_bad;
    logic             cycle_bad;

    generate
        for (genvar k = 0; k < LANES; k++) begin : g_lane
            wpg_lane_check #(.LANE_W(LANE_W)) u_chk (
                .lane     (wr_data[k*LANE_W +: LANE_W]),
                .even_sel (even_sel),
                .bad      (lane_bad[k])
            );
        end
    endgenerate

    wpg_reduce #(.LANES(LANES)) u_red (
        .wr_cycle  (wr_cycle),
        .lane_we   (lane_we),
        .lane_bad  (lane_bad),
        .cycle_bad (cycle_bad)
    );

    wpg_delay u_dly (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample_bad (cycle_bad),
        .pipe_sel   (pipe_sel),
        .flag       (err_drive_low)
    );

    assign err_n = err_drive_low ? 1'b0 : 1'bz;

    logic unused_dw;
    assign unused_dw = (DW == 0);

    AST_READ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_cycle && !pipe_sel) |=> !err_drive_low); // R1
    AST_FLOW_LAT: assert property (@(posedge clk) disable iff (!rst_n)
        (!pipe_sel && wr_cycle && |(lane_bad & lane_we)) |=> err_drive_low); // R2
    AST_PIPE_LAT: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_sel && wr_cycle && |(lane_bad & lane_we)) |=> ##1 err_drive_low); // R3
    AST_MASKED_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        (!pipe_sel && wr_cycle && ((lane_bad & lane_we) == '0)) |=> !err_drive_low); // R6
endmodule

// File: tb/tb_wr_parity_guard.sv
`timescale 1ns/1ps
module tb_wr_parity_guard;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_cycle = 1'b0;
    logic [3:0]  lane_we = '0;
    logic [35:0] wr_data = '0;
    logic        even_sel = 1'b1;
    logic        pipe_sel = 1'b0;
    logic        err_drive_low;
    wire         err_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    logic e1, e2;

    always #5 clk = ~clk;

    wr_parity_guard dut (
        .clk(clk), .rst_n(rst_n), .wr_cycle(wr_cycle), .lane_we(lane_we),
        .wr_data(wr_data), .even_sel(even_sel), .pipe_sel(pipe_sel),
        .err_drive_low(err_drive_low), .err_n(err_n)
    );

    function automatic logic exp_bad(input logic wr, input logic [3:0] we,
                                     input logic [35:0] d, input logic ev);
        logic any = 1'b0;
        for (int k = 0; k < 4; k++) begin
            int ones = $countones(d[k*9 +: 9]);
            logic fail_k = ev ? (ones % 2 == 1) : (ones % 2 == 0);
            if (we[k] && fail_k) any = 1'b1;
        end
        return wr && any;
    endfunction

    task automatic check(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: err_drive_low=%0b expected %0b", tag, act, exp);
        end
    endtask

    // sample output at negedge, then drive next stimulus
    task automatic step(input logic wr, input logic [3:0] we, input logic [35:0] d, input string tag);
        logic expv;
        @(negedge clk);
        expv = pipe_sel ? e2 : e1;
        check(err_drive_low, expv, tag);
        if (err_drive_low === 1'b1) begin
            checks++;
            if (err_n !== 1'b0) begin
                fails++;
                $display("FAIL R9: err_n=%0b expected 0", err_n);
            end
        end
        e2 = e1;
        e1 = exp_bad(wr, we, d, even_sel);
        wr_cycle = wr; lane_we = we; wr_data = d;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_cycle = 1'b0; lane_we = '0; wr_data = '0;
        repeat (2) @(negedge clk);
        checks++;
        if (err_drive_low !== 1'b0) begin
            fails++;
            $display("FAIL R8: err_drive_low=%0b expected 0 in reset", err_drive_low);
        end
        rst_n = 1'b1;
        e1 = 1'b0; e2 = 1'b0;
    endtask

    function automatic logic [8:0] good_lane(input logic [7:0] b, input logic ev);
        return {(^b) ^ ~ev, b};
    endfunction

    initial begin
        e1 = 1'b0; e2 = 1'b0;
        for (int cfg = 0; cfg < 4; cfg++) begin
            pipe_sel = cfg[1];
            even_sel = cfg[0];
            do_reset();
            // exhaustive lane 0 sweep, other lanes correct: R4 R5, tags R2/R3
            for (int v = 0; v < 512; v++) begin
                logic [35:0] d;
                d = {good_lane(8'(v*3), even_sel), good_lane(8'(v*5), even_sel),
                     good_lane(8'(v*7), even_sel), 9'(v)};
                step(1'b1, 4'b0001, d, pipe_sel ? "R3 R4 R5" : "R2 R4 R5");
            end
            // same sweep with writes off: R1
            for (int v = 0; v < 64; v++) begin
                step(1'b0, 4'b1111, {4{9'(v*11)}}, "R1");
            end
            // mixed streams: masking, back-to-back pulses
            for (int n = 0; n < 600; n++) begin
                logic [35:0] d;
                d = {$urandom(), $urandom()} >> 28;
                d = {d[35:32] ^ 4'($urandom()), 32'($urandom())};
                step(($urandom() % 4) != 0, 4'($urandom()), d, "R6 R7");
            end
            // a burst of failing writes, every cycle: R7
            for (int n = 0; n < 8; n++) begin
                step(1'b1, 4'b1000, {good_lane(8'h5a, ~even_sel), 27'd0}, "R7");
            end
            // bad data on disabled lanes only: R6
            for (int n = 0; n < 8; n++) begin
                step(1'b1, 4'b0011, {good_lane(8'h3c, ~even_sel), good_lane(8'h3c, ~even_sel),
                                     good_lane(8'h11, even_sel), good_lane(8'h22, even_sel)}, "R6");
            end
            // drain
            for (int n = 0; n < 3; n++) step(1'b0, 4'b0000, 36'd0, "R1");
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule